// File: doc/BRIEF.md
# Four-Lane PMA/PMD Lane Status and Transmit Control Registers

This block is the management register slice of a four-lane 10 Gb/s physical-layer device. A host reaches it through a plain parallel register port carrying a 16-bit address, write data, a write strobe, a read strobe and registered read data. The serial management frame engine sits outside the block and drives this port. The block keeps the per-lane and global transmit-disable controls. It reports per-lane and global signal-detect status and fixed capability words. It also latches per-lane fault events until software reads them.

A mode input chooses between two lane flavours, optical-style and copper-style. In optical-style mode, signal detect comes from an external active-high loss-of-signal input, and a disabled lane loses only its transmit-enable output. In copper-style mode, signal detect comes from the device's internal copper detect levels, and a disabled lane has its differential output driver switched off instead. An external transmit-on level must be high for any lane to send.

Top module: `lane_mgmt_regs`

## Requirements
- R1: While `rst` is high, every `tx_en` bit is 0 and every `drv_off` bit is 1. After reset, the transmit-disable register (address 0x0009) reads 0. Read data appears on `rd_data` on the clock edge that samples `rd_en`.
- R2: Register 0x0009 is read/write. Bit 0 disables all lanes, and bit n+1 disables lane n. Bits 15:5 ignore writes and read 0.
- R3: A lane is allowed to send only when its own disable bit is 0, the disable-all bit is 0 and `tx_on` is 1. In optical-style mode (`mode_cx4`=0), `tx_en[n]` shows that permission one clock after the inputs and `drv_off` is 0.
- R4: In copper-style mode (`mode_cx4`=1), `tx_en` is all ones and `drv_off[n]` is the inverse of lane n's permission, one clock after the inputs.
- R5: Register 0x000A is read-only, and bit n+1 shows lane n signal detect. In optical-style mode, lane n's detect is the inverse of `los_in[n]`, taken through a two-flop synchronizer.
- R6: In copper-style mode, the per-lane detect bits of register 0x000A follow `cx4_det` directly.
- R7: Bit 0 of register 0x000A is 1 exactly when all four lane detect bits are 1.
- R8: Register 0x0008 always reads 0x0011 (loopback bit 0 and optical-style bit 4 set). Register 0x000B always reads 0x0001 (copper-style bit 0 set).
- R9: A high level on `fault_in[n]` sets bit n of the fault register (address 0x0001), and the bit stays set. A read returns the latched value and clears the register.
- R10: A read of either alarm summary register (0x9003 or 0x9004) returns bit 0 = 1 if any fault bit is latched, and clears all latched fault bits.
- R11: A fault that arrives in the same cycle as a clearing read is not part of that read's data, but it stays latched for the next read.
- R12: Writes to read-only registers have no effect, and reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 16 | Register address |
| wr_data | input | 16 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (reads of fault and alarm registers clear faults) |
| rd_data | output | 16 | Registered read data |
| mode_cx4 | input | 1 | 1 = copper-style lanes, 0 = optical-style lanes |
| tx_on | input | 1 | External transmit-on level, high allows sending |
| los_in | input | 4 | Asynchronous active-high loss of signal per lane |
| cx4_det | input | 4 | Internal copper signal-detect levels per lane |
| fault_in | input | 4 | Per-lane fault event levels |
| tx_en | output | 4 | Per-lane transmit enable (optical-style gating) |
| drv_off | output | 4 | Per-lane output driver disable (copper-style gating) |

## Verification
On every clock, the assertions check the transmit gating rules in both modes. They also check that a raised fault input always leaves its bit latched and that a latched bit never drops without a clearing read. Each read of the capability, disable and signal-detect registers is checked for its fixed bits, its reserved zeros and its global-AND bit. Some behaviour can only be shown by the bench's scenarios: the decoded bit positions seen from the host, the synchronizer delay on the loss inputs, clearing through the alarm registers, and a fault that coincides with a read.

// File: rtl/lane_mgmt_pkg.sv
package lane_mgmt_pkg;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned DATA_W = 16;

  localparam logic [ADDR_W-1:0] A_FAULT   = 16'h0001;
  localparam logic [ADDR_W-1:0] A_CAP_A   = 16'h0008;
  localparam logic [ADDR_W-1:0] A_TXDIS   = 16'h0009;
  localparam logic [ADDR_W-1:0] A_SIGDET  = 16'h000A;
  localparam logic [ADDR_W-1:0] A_CAP_B   = 16'h000B;
  localparam logic [ADDR_W-1:0] A_ALARM_0 = 16'h9003;
  localparam logic [ADDR_W-1:0] A_ALARM_1 = 16'h9004;

  localparam logic [DATA_W-1:0] CAP_A_VAL = 16'h0011;
  localparam logic [DATA_W-1:0] CAP_B_VAL = 16'h0001;
endpackage

// File: rtl/lane_sigdet_sel.sv
module lane_sigdet_sel #(
  parameter int unsigned LANES       = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_cx4,
  input  logic [LANES-1:0] los_in,
  input  logic [LANES-1:0] cx4_det,
  output logic [LANES-1:0] det
);
  logic [LANES-1:0] sync_q [SYNC_STAGES];

  genvar s;
  generate
    for (s = 0; s < SYNC_STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) sync_q[s] <= '1;
          else     sync_q[s] <= los_in;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (rst) sync_q[s] <= '1;
          else     sync_q[s] <= sync_q[s-1];
        end
      end
    end
  endgenerate

  // loss is active high; detect is its inverse
  assign det = mode_cx4 ? cx4_det : ~sync_q[SYNC_STAGES-1];
endmodule

// File: rtl/lane_fault_latch.sv
module lane_fault_latch #(
  parameter int unsigned LANES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LANES-1:0] fault_in,
  input  logic             clr,
  output logic [LANES-1:0] fault_q
);
  // a new event always wins over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (rst) fault_q <= '0;
    else     fault_q <= (clr ? '0 : fault_q) | fault_in;
  end
endmodule

// File: rtl/lane_tx_gate.sv
module lane_tx_gate #(
  parameter int unsigned LANES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_cx4,
  input  logic             tx_on,
  input  logic             dis_all,
  input  logic [LANES-1:0] dis_lane,
  output logic [LANES-1:0] tx_en,
  output logic [LANES-1:0] drv_off
);
  logic [LANES-1:0] permit;

  genvar n;
  generate
    for (n = 0; n < LANES; n++) begin : g_lane
      assign permit[n] = tx_on & ~dis_all & ~dis_lane[n];
      always_ff @(posedge clk) begin
        if (rst) begin
          tx_en[n]   <= 1'b0;
          drv_off[n] <= 1'b1;
        end else if (mode_cx4) begin
          tx_en[n]   <= 1'b1;
          drv_off[n] <= ~permit[n];
        end else begin
          tx_en[n]   <= permit[n];
          drv_off[n] <= 1'b0;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/lane_mgmt_regs.sv
module lane_mgmt_regs
  import lane_mgmt_pkg::*;
#(
  parameter int unsigned LANES       = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  input  logic              mode_cx4,
  input  logic              tx_on,
  input  logic [LANES-1:0]  los_in,
  input  logic [LANES-1:0]  cx4_det,
  input  logic [LANES-1:0]  fault_in,
  output logic [LANES-1:0]  tx_en,
  output logic [LANES-1:0]  drv_off
);
  localparam int unsigned CTL_W = LANES + 1;

  logic [CTL_W-1:0]  txdis_q;
  logic [LANES-1:0]  det;
  logic [LANES-1:0]  fault_q;
  logic              fault_clr;
  logic [DATA_W-1:0] rd_mux;

  always_ff @(posedge clk) begin
    if (rst)                             txdis_q <= '0;
    else if (wr_en && addr == A_TXDIS)   txdis_q <= wr_data[CTL_W-1:0];
  end

  assign fault_clr = rd_en && (addr == A_FAULT || addr == A_ALARM_0 || addr == A_ALARM_1);

  lane_sigdet_sel #(.LANES(LANES), .SYNC_STAGES(SYNC_STAGES)) u_sd (
    .clk(clk), .rst(rst), .mode_cx4(mode_cx4),
    .los_in(los_in), .cx4_det(cx4_det), .det(det)
  );

  lane_fault_latch #(.LANES(LANES)) u_flt (
    .clk(clk), .rst(rst), .fault_in(fault_in), .clr(fault_clr), .fault_q(fault_q)
  );

  lane_tx_gate #(.LANES(LANES)) u_tx (
    .clk(clk), .rst(rst), .mode_cx4(mode_cx4), .tx_on(tx_on),
    .dis_all(txdis_q[0]), .dis_lane(txdis_q[CTL_W-1:1]),
    .tx_en(tx_en), .drv_off(drv_off)
  );

  always_comb begin
    rd_mux = '0;
    unique case (addr)
      A_FAULT:   rd_mux[LANES-1:0] = fault_q;
      A_CAP_A:   rd_mux = CAP_A_VAL;
      A_TXDIS:   rd_mux[CTL_W-1:0] = txdis_q;
      A_SIGDET:  rd_mux[CTL_W-1:0] = {det, &det};
      A_CAP_B:   rd_mux = CAP_B_VAL;
      A_ALARM_0,
      A_ALARM_1: rd_mux[0] = |fault_q;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;
  end
endmodule

// File: rtl/lane_mgmt_chk.sv
module lane_mgmt_chk
  import lane_mgmt_pkg::*;
#(
  parameter int unsigned LANES = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr,
  input logic              rd_en,
  input logic [DATA_W-1:0] rd_data,
  input logic              mode_cx4,
  input logic              tx_on,
  input logic [LANES:0]    txdis_q,
  input logic [LANES-1:0]  fault_in,
  input logic [LANES-1:0]  fault_q,
  input logic              fault_clr,
  input logic [LANES-1:0]  tx_en,
  input logic [LANES-1:0]  drv_off
);
  logic past_ok;
  always_ff @(posedge clk) past_ok <= !rst;

  // R3
  lx4_tx_off_chk: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(!mode_cx4 && (!tx_on || txdis_q[0])) |-> tx_en == '0);
  // R3
  lx4_drv_on_chk: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(!mode_cx4) |-> drv_off == '0);
  // R4
  cx4_en_high_chk: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(mode_cx4) |-> tx_en == '1);
  // R4
  cx4_drv_off_chk: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(mode_cx4 && (!tx_on || txdis_q[0])) |-> drv_off == '1);
  // R9
  fault_capture_chk: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(fault_in != '0) |-> (fault_q & $past(fault_in)) == $past(fault_in));
  // R11
  fault_hold_chk: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(!fault_clr) |-> (fault_q & $past(fault_q)) == $past(fault_q));
  // R8
  cap_a_chk: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(rd_en && addr == A_CAP_A) |-> rd_data == CAP_A_VAL);
  // R7
  glob_and_chk: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(rd_en && addr == A_SIGDET) |-> rd_data[0] == &rd_data[LANES:1]);
  // R2
  txdis_rsvd_chk: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(rd_en && addr == A_TXDIS) |-> rd_data[DATA_W-1:LANES+1] == '0);
endmodule

bind lane_mgmt_regs lane_mgmt_chk #(.LANES(LANES)) u_chk (
  .clk(clk), .rst(rst), .addr(addr), .rd_en(rd_en), .rd_data(rd_data),
  .mode_cx4(mode_cx4), .tx_on(tx_on), .txdis_q(txdis_q), .fault_in(fault_in),
  .fault_q(fault_q), .fault_clr(fault_clr), .tx_en(tx_en), .drv_off(drv_off)
);

// File: tb/tb_lane_mgmt_regs.sv
module tb_lane_mgmt_regs;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] addr = '0;
  logic [15:0] wr_data = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [15:0] rd_data;
  logic        mode_cx4 = 1'b0;
  logic        tx_on = 1'b1;
  logic [3:0]  los_in = '0;
  logic [3:0]  cx4_det = '0;
  logic [3:0]  fault_in = '0;
  logic [3:0]  tx_en;
  logic [3:0]  drv_off;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  lane_mgmt_regs dut (
    .clk(clk), .rst(rst), .addr(addr), .wr_data(wr_data), .wr_en(wr_en),
    .rd_en(rd_en), .rd_data(rd_data), .mode_cx4(mode_cx4), .tx_on(tx_on),
    .los_in(los_in), .cx4_det(cx4_det), .fault_in(fault_in),
    .tx_en(tx_en), .drv_off(drv_off)
  );

  typedef struct packed {
    logic       mode;
    logic       txon;
    logic [4:0] dis;
    logic [3:0] los;
    logic [3:0] cx4;
    logic [4:0] sd;
    logic [3:0] en;
    logic [3:0] drv;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b1, 5'h00, 4'h0, 4'h0, 5'h1F, 4'hF, 4'h0},
    '{1'b0, 1'b1, 5'h04, 4'h5, 4'h0, 5'h14, 4'hD, 4'h0},
    '{1'b0, 1'b0, 5'h00, 4'hF, 4'h0, 5'h00, 4'h0, 4'h0},
    '{1'b0, 1'b1, 5'h01, 4'h0, 4'h0, 5'h1F, 4'h0, 4'h0},
    '{1'b1, 1'b1, 5'h00, 4'hF, 4'hF, 5'h1F, 4'hF, 4'h0},
    '{1'b1, 1'b1, 5'h12, 4'h0, 4'h6, 5'h0C, 4'hF, 4'h9},
    '{1'b1, 1'b0, 5'h00, 4'h0, 4'h8, 5'h10, 4'hF, 4'hF},
    '{1'b1, 1'b1, 5'h01, 4'h0, 4'hF, 5'h1F, 4'hF, 4'hF},
    '{1'b0, 1'b1, 5'h1E, 4'hE, 4'h0, 5'h02, 4'h0, 4'h0}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [15:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] d;
    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1 tx_en in reset", {12'h0, tx_en}, 16'h0000);
    check("R1 drv_off in reset", {12'h0, drv_off}, 16'h000F);
    rst = 1'b0;
    rd(16'h0009, d);
    check("R1 txdis after reset", d, 16'h0000);

    // table walk: R2 R3 R4 R5 R6 R7
    for (int i = 0; i < NV; i++) begin
      mode_cx4 = VECS[i].mode;
      tx_on    = VECS[i].txon;
      los_in   = VECS[i].los;
      cx4_det  = VECS[i].cx4;
      wr(16'h0009, {11'h0, VECS[i].dis});
      repeat (4) @(negedge clk);
      rd(16'h000A, d);
      check("R5/R6/R7 sigdet", d, {11'h0, VECS[i].sd});
      check("R3/R4 tx_en", {12'h0, tx_en}, {12'h0, VECS[i].en});
      check("R3/R4 drv_off", {12'h0, drv_off}, {12'h0, VECS[i].drv});
      rd(16'h0009, d);
      check("R2 txdis readback", d, {11'h0, VECS[i].dis});
    end

    // R5 two-flop delay: optical mode, loss rises on lane 0
    mode_cx4 = 1'b0; los_in = 4'h0; cx4_det = 4'h0;
    wr(16'h0009, 16'h0000);
    repeat (3) @(negedge clk);
    @(negedge clk);
    los_in = 4'h1; addr = 16'h000A; rd_en = 1'b1;
    @(negedge clk);
    d = rd_data;
    check("R5 sync delay 0", d, 16'h001F);
    @(negedge clk);
    d = rd_data;
    check("R5 sync delay 1", d, 16'h001F);
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
    check("R5 sync delay 2", d, 16'h001C);
    los_in = 4'h0;

    // R2 reserved bits
    wr(16'h0009, 16'hFFFF);
    rd(16'h0009, d);
    check("R2 reserved read zero", d, 16'h001F);
    wr(16'h0009, 16'h0000);

    // R8 capability
    rd(16'h0008, d);
    check("R8 cap A", d, 16'h0011);
    rd(16'h000B, d);
    check("R8 cap B", d, 16'h0001);

    // R12 read-only writes ignored, unmapped reads
    wr(16'h0008, 16'h0000);
    rd(16'h0008, d);
    check("R12 cap write ignored", d, 16'h0011);
    repeat (3) @(negedge clk);
    wr(16'h000A, 16'h0000);
    rd(16'h000A, d);
    check("R12 sigdet write ignored", d, 16'h001F);
    rd(16'h1234, d);
    check("R12 unmapped read", d, 16'h0000);

    // R9 latch and clear on read
    @(negedge clk); fault_in = 4'h4;
    @(negedge clk); fault_in = 4'h0;
    repeat (2) @(negedge clk);
    rd(16'h0001, d);
    check("R9 fault latched", d, 16'h0004);
    rd(16'h0001, d);
    check("R9 fault cleared", d, 16'h0000);

    // R10 alarm register clears
    @(negedge clk); fault_in = 4'h8;
    @(negedge clk); fault_in = 4'h0;
    rd(16'h9003, d);
    check("R10 alarm 9003 bit0", d, 16'h0001);
    rd(16'h0001, d);
    check("R10 cleared via 9003", d, 16'h0000);
    @(negedge clk); fault_in = 4'h1;
    @(negedge clk); fault_in = 4'h0;
    rd(16'h9004, d);
    check("R10 alarm 9004 bit0", d, 16'h0001);
    rd(16'h9004, d);
    check("R10 cleared via 9004", d, 16'h0000);

    // R11 fault coincident with clearing read
    @(negedge clk); fault_in = 4'h4;
    @(negedge clk); fault_in = 4'h0;
    @(negedge clk);
    addr = 16'h0001; rd_en = 1'b1; fault_in = 4'h2;
    @(negedge clk);
    rd_en = 1'b0; fault_in = 4'h0;
    check("R11 read returns prior", rd_data, 16'h0004);
    rd(16'h0001, d);
    check("R11 coincident fault kept", d, 16'h0002);

    finish_run();
  end
endmodule